// File: doc/BRIEF.md
# Return-From-Interrupt Sequencer

This block is the multi-cycle control slice of a small 8-bit processor core that executes the return-from-interrupt instruction. When the core offers an instruction word with `start_i` high and the sequencer is idle, the block compares the word with the single return-from-interrupt encoding. On a match it takes over the core's stack pointer and interrupt-enable flag. It then reads the return address from a byte-wide stack memory, one byte per cycle, through a read port with one cycle of latency. Any other word is ignored.

The stack pointer is incremented before each read. The first byte read is the most significant byte of the return address. A 16-bit program counter needs two pops and a 22-bit one needs three; the parameter `PC_W` selects which. After the last byte has been captured, the new program counter, stack pointer and interrupt-enable flag appear on the outputs, and `done_o` pulses for one cycle. The parameter `CLASSIC` selects how the interrupt-enable flag is treated. In the classic variant the instruction sets the flag. In the newer variants the flag passes through with its value unchanged. The block never reads or writes any other status flag.

Top module: `reti_seq`

## Requirements
- R1: An instruction is accepted only when `start_i` is high, the sequencer is idle, and `opcode_i` equals 16'h9518 (binary 1001010100011000).
- R2: A non-matching opcode leaves `pc_o`, `sp_o` and `ie_o` unchanged, issues no stack read and produces no `done_o`.
- R3: Each stack read is pre-incremented. The read address is the current stack pointer plus one, and `sp_o` takes that address on the following cycle.
- R4: With `PC_W`=16 exactly two bytes are read and `sp_o` ends at the starting pointer plus 2. With `PC_W`=22 exactly three bytes are read and `sp_o` ends at the starting pointer plus 3. The pointer wraps modulo 2^`SP_W`.
- R5: The first byte read becomes the most significant byte of the return address. `pc_o` receives the low `PC_W` bits of the bytes read, concatenated in read order.
- R6: With `CLASSIC`=1, `ie_o` is 1 when `done_o` is asserted, whatever the value of `ie_i`.
- R7: With `CLASSIC`=0, `ie_o` equals the `ie_i` value sampled with the accepted instruction.
- R8: The instruction takes 4 cycles with `PC_W`=16 and 5 cycles with `PC_W`=22, counting the cycle in which `start_i` is accepted. `done_o` is a single-cycle pulse in the last of these cycles.
- R9: After a synchronous active-high reset, `done_o` and `mem_re_o` are low and `pc_o`, `sp_o` and `ie_o` are zero.
- R10: `start_i` is ignored while a sequence is in progress, including its final cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Instruction word offered for execution |
| opcode_i | input | 16 | Instruction word |
| sp_i | input | SP_W | Stack pointer at instruction start |
| ie_i | input | 1 | Interrupt-enable flag at instruction start |
| mem_re_o | output | 1 | Stack memory read enable |
| mem_addr_o | output | SP_W | Stack memory read address |
| mem_rdata_i | input | 8 | Stack memory read data, one cycle after the request |
| pc_o | output | PC_W | Program counter result |
| sp_o | output | SP_W | Stack pointer result |
| ie_o | output | 1 | Interrupt-enable flag result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong pop counter shows up straight away at the ports: `done_o` arrives a cycle early or late, and `sp_o` settles one byte off. A byte captured in the wrong slot or at the wrong time leaves a scrambled `pc_o` in the completion cycle. Reading the stale data register one cycle too soon repeats a byte. A decoder or idle test that is too loose starts a stack read in the very cycle the stray word is offered. The tests use a pointer near the top of the address space to expose wrap errors, and they re-offer the instruction while a sequence is running to show that no new one starts.

// File: rtl/reti_pkg.sv
package reti_pkg;

    localparam logic [15:0] OPC_RETI = 16'h9518;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_POP,
        ST_LAST,
        ST_DONE
    } seq_st_e;

endpackage

// File: rtl/reti_decode.sv
module reti_decode (
    input  logic [15:0] opcode_i,
    output logic        hit_o
);
    assign hit_o = (opcode_i == reti_pkg::OPC_RETI);
endmodule

// File: rtl/reti_ie_policy.sv
module reti_ie_policy #(
    parameter bit CLASSIC = 1'b1
) (
    input  logic ie_i,
    output logic ie_o
);
    generate
        if (CLASSIC) begin : g_set
            assign ie_o = ie_i | 1'b1;
        end else begin : g_keep
            assign ie_o = ie_i;
        end
    endgenerate
endmodule

// File: rtl/reti_seq.sv
module reti_seq #(
    parameter int PC_W    = 16,
    parameter int SP_W    = 16,
    parameter bit CLASSIC = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [15:0]     opcode_i,
    input  logic [SP_W-1:0] sp_i,
    input  logic            ie_i,
    output logic            mem_re_o,
    output logic [SP_W-1:0] mem_addr_o,
    input  logic [7:0]      mem_rdata_i,
    output logic [PC_W-1:0] pc_o,
    output logic [SP_W-1:0] sp_o,
    output logic            ie_o,
    output logic            done_o
);
    import reti_pkg::*;

    localparam int NBYTES = (PC_W + 7) / 8;
    localparam int CNT_W  = (NBYTES > 2) ? $clog2(NBYTES) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(NBYTES - 2);

    typedef struct packed {
        seq_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic [SP_W-1:0] sp;
        logic [PC_W-1:0] acc;
        logic [PC_W-1:0] pc;
        logic            ie;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic hit;
    logic ie_ret;

    reti_decode u_dec (
        .opcode_i (opcode_i),
        .hit_o    (hit)
    );

    reti_ie_policy #(.CLASSIC(CLASSIC)) u_iep (
        .ie_i (cur_q.ie),
        .ie_o (ie_ret)
    );

    always_comb begin
        nxt_d      = cur_q;
        mem_re_o   = 1'b0;
        mem_addr_o = cur_q.sp + 1'b1;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (start_i && hit) begin
                    mem_re_o   = 1'b1;
                    mem_addr_o = sp_i + 1'b1;
                    nxt_d.sp   = sp_i + 1'b1;
                    nxt_d.ie   = ie_i;
                    nxt_d.cnt  = '0;
                    nxt_d.st   = ST_POP;
                end
            end
            ST_POP: begin
                mem_re_o  = 1'b1;
                nxt_d.sp  = cur_q.sp + 1'b1;
                nxt_d.acc = PC_W'({cur_q.acc, mem_rdata_i});
                nxt_d.cnt = cur_q.cnt + 1'b1;
                if (cur_q.cnt == CNT_END) begin
                    nxt_d.st = ST_LAST;
                end
            end
            ST_LAST: begin
                nxt_d.pc = PC_W'({cur_q.acc, mem_rdata_i});
                nxt_d.ie = ie_ret;
                nxt_d.st = ST_DONE;
            end
            ST_DONE: begin
                nxt_d.st = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{st: ST_IDLE, cnt: '0, sp: '0, acc: '0, pc: '0, ie: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pc_o   = cur_q.pc;
    assign sp_o   = cur_q.sp;
    assign ie_o   = cur_q.ie;
    assign done_o = (cur_q.st == ST_DONE);

endmodule

// File: rtl/reti_seq_chk.sv
module reti_seq_chk #(
    parameter int PC_W    = 16,
    parameter int SP_W    = 16,
    parameter bit CLASSIC = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic            start_i,
    input logic [15:0]     opcode_i,
    input logic [SP_W-1:0] sp_i,
    input logic            ie_i,
    input logic            mem_re_o,
    input logic [SP_W-1:0] mem_addr_o,
    input logic [PC_W-1:0] pc_o,
    input logic [SP_W-1:0] sp_o,
    input logic            ie_o,
    input logic            done_o
);
    localparam int NB = (PC_W + 7) / 8;

    logic            busy_q;
    logic [3:0]      cyc_q;
    logic [SP_W-1:0] sp0_q;
    logic            ie0_q;
    logic            take;

    assign take = start_i && !busy_q && (opcode_i == reti_pkg::OPC_RETI);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cyc_q  <= '0;
            sp0_q  <= '0;
            ie0_q  <= 1'b0;
        end else if (take) begin
            busy_q <= 1'b1;
            cyc_q  <= 4'd1;
            sp0_q  <= sp_i;
            ie0_q  <= ie_i;
        end else if (done_o) begin
            busy_q <= 1'b0;
            cyc_q  <= '0;
        end else if (busy_q) begin
            cyc_q  <= cyc_q + 4'd1;
        end
    end

    AST_PREINC: assert property (@(posedge clk) disable iff (rst)
        mem_re_o |=> (sp_o == $past(mem_addr_o))); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

    AST_DONE_CYCLES: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (busy_q && cyc_q == 4'(NB + 1))); // R8

    AST_SP_FINAL: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (sp_o == sp0_q + SP_W'(NB))); // R4

    AST_IE_SET: assert property (@(posedge clk) disable iff (rst)
        (CLASSIC && done_o) |-> ie_o); // R6

    AST_IE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!CLASSIC && done_o) |-> (ie_o == ie0_q)); // R7

    AST_NO_STRAY_READ: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_q && opcode_i != reti_pkg::OPC_RETI) |-> !mem_re_o); // R2

    AST_STRAY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_q && opcode_i != reti_pkg::OPC_RETI)
        |=> ($stable(pc_o) && $stable(sp_o) && $stable(ie_o))); // R2

endmodule

bind reti_seq reti_seq_chk #(.PC_W(PC_W), .SP_W(SP_W), .CLASSIC(CLASSIC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .opcode_i   (opcode_i),
    .sp_i       (sp_i),
    .ie_i       (ie_i),
    .mem_re_o   (mem_re_o),
    .mem_addr_o (mem_addr_o),
    .pc_o       (pc_o),
    .sp_o       (sp_o),
    .ie_o       (ie_o),
    .done_o     (done_o)
);

// File: tb/reti_seq_tb.sv
`timescale 1ns/1ps
module reti_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] opc = 16'h0000;
    logic [15:0] spi = 16'h0000;
    logic        iei = 1'b0;

    logic        re16, re22, done16, done22, ie16, ie22;
    logic [15:0] addr16, addr22, sp16, sp22, pc16;
    logic [21:0] pc22;
    logic [7:0]  rd16, rd22;
    logic [7:0]  memb [256];

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    // PC_W=16, classic variant
    reti_seq #(.PC_W(16), .SP_W(16), .CLASSIC(1'b1)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .opcode_i(opc), .sp_i(spi), .ie_i(iei),
        .mem_re_o(re16), .mem_addr_o(addr16), .mem_rdata_i(rd16),
        .pc_o(pc16), .sp_o(sp16), .ie_o(ie16), .done_o(done16));

    // PC_W=22, newer variant
    reti_seq #(.PC_W(22), .SP_W(16), .CLASSIC(1'b0)) u_dut22 (
        .clk(clk), .rst(rst), .start_i(start), .opcode_i(opc), .sp_i(spi), .ie_i(iei),
        .mem_re_o(re22), .mem_addr_o(addr22), .mem_rdata_i(rd22),
        .pc_o(pc22), .sp_o(sp22), .ie_o(ie22), .done_o(done22));

    always @(posedge clk) begin
        if (re16) rd16 <= memb[addr16[7:0]];
        if (re22) rd22 <= memb[addr22[7:0]];
    end

    function automatic logic [7:0] mb(input logic [15:0] a);
        return memb[a[7:0]];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!done16 && !done22, "R9 done low", {30'd0, done16, done22}, 32'd0);
        chk(!re16 && !re22, "R9 no read", {30'd0, re16, re22}, 32'd0);
        chk(pc16 == 0 && sp16 == 0 && !ie16, "R9 regs16 zero", {pc16, sp16}, 32'd0);
        chk(pc22 == 0 && sp22 == 0 && !ie22, "R9 regs22 zero", {10'd0, pc22}, 32'd0);
    endtask

    // hold_busy: re-offer the opcode with another pointer while running (R10)
    task automatic t_run(input logic [15:0] sp0, input logic ie0, input bit hold_busy, input string nm);
        int t16 = 0, t22 = 0, n16 = 0, n22 = 0;
        logic [23:0] raw;
        @(negedge clk);
        start = 1'b1; opc = 16'h9518; spi = sp0; iei = ie0;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            if (k == 1 && hold_busy) begin spi = sp0 + 16'h0040; iei = ~ie0; end
            if (k == 1 && !hold_busy) start = 1'b0;
            if (k == 3) start = 1'b0;
            if (done16) begin n16++; t16 = k; end
            if (done22) begin n22++; t22 = k; end
        end
        raw = {mb(sp0 + 16'd1), mb(sp0 + 16'd2), mb(sp0 + 16'd3)};
        chk(n16 == 1 && t16 == 3, {nm, " R8 cycles16"}, t16, 3);
        chk(n22 == 1 && t22 == 4, {nm, " R8 cycles22"}, t22, 4);
        chk(pc16 == raw[23:8], {nm, " R5 R10 pc16"}, pc16, raw[23:8]);
        chk(pc22 == raw[21:0], {nm, " R5 R10 pc22"}, pc22, raw[21:0]);
        chk(sp16 == sp0 + 16'd2, {nm, " R3 R4 sp16"}, sp16, sp0 + 16'd2);
        chk(sp22 == sp0 + 16'd3, {nm, " R3 R4 sp22"}, sp22, sp0 + 16'd3);
        chk(ie16 == 1'b1, {nm, " R6 ie classic"}, ie16, 1);
        chk(ie22 == ie0, {nm, " R7 ie kept"}, ie22, ie0);
    endtask

    task automatic t_mismatch(input logic [15:0] bad);
        logic [15:0] p16 = pc16, s16 = sp16, s22 = sp22;
        logic [21:0] p22 = pc22;
        int nre = 0, nd = 0;
        @(negedge clk);
        start = 1'b1; opc = bad; spi = 16'h0011; iei = ~ie22;
        for (int k = 1; k <= 6; k++) begin
            if (re16 || re22) nre++;
            @(negedge clk);
            if (k == 2) start = 1'b0;
            if (done16 || done22) nd++;
        end
        chk(nre == 0 && nd == 0, "R1 R2 no read no done", nre + nd, 0);
        chk(pc16 == p16 && sp16 == s16, "R2 state16 kept", {pc16, sp16}, {p16, s16});
        chk(pc22 == p22 && sp22 == s22, "R2 state22 kept", {10'd0, pc22}, {10'd0, p22});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) memb[i] = 8'(i * 37 + 11);
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_run(16'h0020, 1'b0, 1'b0, "basic ie0");
        t_run(16'h0090, 1'b1, 1'b0, "basic ie1");
        t_mismatch(16'h9519);
        t_mismatch(16'h1895);
        t_run(16'hFFFE, 1'b0, 1'b0, "wrap");
        t_run(16'h0030, 1'b1, 1'b1, "busy restart");
        t_run(16'h00C7, 1'b0, 1'b0, "back to back");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule